// File: doc/BRIEF.md
# Next Program Counter Unit for a 32-bit RISC Core

This block decides where a 32-bit RISC core fetches its next instruction. Each cycle it takes the address of the current instruction, the instruction word itself, the two source register values read for it and a register value for indirect jumps. It then produces the following fetch address and, for the call instruction, a request to write the return address into the link register. It recognises six kinds of flow: plain sequential execution, branch-if-equal, branch-if-not-equal, absolute jump, jump-and-link (call) and jump-through-register.

All results are registered. An instruction presented on the inputs before a rising clock edge has its next address, link request and link data on the outputs right after that edge. The core feeds the next address back as its program counter and the link request to its register file write port. Delay slots, prediction and misaligned-target traps are handled elsewhere.

Branch targets are relative to the following instruction and measured in words. Jump targets are pseudodirect: 26 target bits shifted up by two, with the upper four address bits taken from the address of the following instruction. A jump can therefore never leave its 256 MB region.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted, `npc_o` equals the parameter `RESET_PC` and `link_we_o` is 0.
- R2: Any instruction other than the five flow instructions yields `npc_o = pc_i + 4`. This includes an opcode-0 word whose function field is not 001000.
- R3: Branch-if-equal is opcode 4 in bits 31:26. When `rs_val_i == rt_val_i` it goes to `pc_i + 4 + 4*offset`, where offset is bits 15:0. Otherwise it goes to `pc_i + 4`.
- R4: Branch-if-not-equal is opcode 5. It takes the same target when the operands differ and falls through to `pc_i + 4` when they are equal.
- R5: The 16-bit branch offset is treated as signed, so a negative offset moves the address backward.
- R6: Jump is opcode 2. `npc_o` becomes `{(pc_i+4)[31:28], instr_i[25:0], 2'b00}`.
- R7: Jump-and-link is opcode 3. It jumps exactly like R6 and, in the same cycle, raises `link_we_o`, sets `link_reg_o` to 31 and sets `link_data_o` to `pc_i + 4`.
- R8: Jump-through-register is opcode 0 with function field (bits 5:0) equal to 001000. `npc_o` becomes `jr_val_i`.
- R9: `link_we_o` is 1 only for jump-and-link and is 0 for every other instruction.
- R10: The region bits of a jump target come from `pc_i + 4`. A jump placed in the last word of a region therefore lands in the next region.
- R11: Outputs reflect the inputs sampled at the preceding rising clock edge. Back-to-back instructions each produce their own result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| jr_val_i | input | 32 | Register value for jump-through-register |
| npc_o | output | 32 | Registered next fetch address |
| link_we_o | output | 1 | Registered link-register write request |
| link_reg_o | output | 5 | Index of the link register |
| link_data_o | output | 32 | Return address to write |

## Verification
On every cycle, the bound checker relates the registered outputs to the inputs of the previous cycle. It confirms the sequential advance for non-flow opcodes, the jump region bits, the register-indirect target, both taken branch targets and that the link request appears only behind a call. The bench's scenarios show the rest: the reset value, not-taken branches, backward branches, a jump in the last word of a region, an opcode-0 word that is not a register jump, and a dense run of mixed instructions that proves the one-cycle latency holds back to back.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN     = 32;
  localparam int OP_W     = 6;
  localparam int FUNCT_W  = 6;
  localparam int IMM_W    = 16;
  localparam int JTGT_W   = 26;
  localparam int REGION_W = XLEN - JTGT_W - 2;
  localparam int REGIDX_W = 5;
  localparam int SEXT_W   = XLEN - IMM_W - 2;

  localparam logic [OP_W-1:0]    OP_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0]    OP_JMP     = 6'd2;
  localparam logic [OP_W-1:0]    OP_CALL    = 6'd3;
  localparam logic [OP_W-1:0]    OP_BREQ    = 6'd4;
  localparam logic [OP_W-1:0]    OP_BRNE    = 6'd5;
  localparam logic [FUNCT_W-1:0] FN_REGJMP  = 6'b001000;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BREQ,
    FLOW_BRNE,
    FLOW_JMP,
    FLOW_CALL,
    FLOW_REGJMP
  } flow_e;

  // address of the following word
  function automatic logic [XLEN-1:0] fn_seq_pc(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  // word offset, sign extended, relative to the following word
  function automatic logic [XLEN-1:0] fn_branch_pc(input logic [XLEN-1:0] pc,
                                                   input logic [IMM_W-1:0] imm);
    logic [XLEN-1:0] ofs;
    ofs = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    return fn_seq_pc(pc) + ofs;
  endfunction

  // pseudodirect target; region bits from the following word
  function automatic logic [XLEN-1:0] fn_jump_pc(input logic [XLEN-1:0] pc,
                                                 input logic [JTGT_W-1:0] tgt);
    logic [XLEN-1:0] nxt;
    nxt = fn_seq_pc(pc);
    return {nxt[XLEN-1 -: REGION_W], tgt, 2'b00};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output flow_e           kind
);
  logic [OP_W-1:0]    opcode;
  logic [FUNCT_W-1:0] funct;

  assign opcode = instr[XLEN-1 -: OP_W];
  assign funct  = instr[FUNCT_W-1:0];

  always_comb begin
    kind = FLOW_SEQ;
    unique case (opcode)
      OP_BREQ: kind = FLOW_BREQ;
      OP_BRNE: kind = FLOW_BRNE;
      OP_JMP:  kind = FLOW_JMP;
      OP_CALL: kind = FLOW_CALL;
      OP_SPECIAL: if (funct == FN_REGJMP) kind = FLOW_REGJMP;
      default: kind = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  flow_e           kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            taken
);
  logic same;
  assign same = (opa == opb);

  always_comb begin
    case (kind)
      FLOW_BREQ: taken = same;
      FLOW_BRNE: taken = !same;
      default:   taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] br_pc,
  output logic [XLEN-1:0] jmp_pc
);
  assign seq_pc = fn_seq_pc(pc);
  assign br_pc  = fn_branch_pc(pc, instr[IMM_W-1:0]);
  assign jmp_pc = fn_jump_pc(pc, instr[JTGT_W-1:0]);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          LINK_REG = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pc_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  input  logic [31:0] jr_val_i,
  output logic [31:0] npc_o,
  output logic        link_we_o,
  output logic [4:0]  link_reg_o,
  output logic [31:0] link_data_o
);
  // named internal events
  flow_e           flow_kind;
  logic            br_taken;
  logic            is_call;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] jmp_pc;
  logic [XLEN-1:0] npc_d;

  npc_decode u_decode (
    .instr (instr_i),
    .kind  (flow_kind)
  );

  npc_cond u_cond (
    .kind  (flow_kind),
    .opa   (rs_val_i),
    .opb   (rt_val_i),
    .taken (br_taken)
  );

  npc_targets u_targets (
    .pc     (pc_i),
    .instr  (instr_i),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc)
  );

  assign is_call = (flow_kind == FLOW_CALL);

  always_comb begin
    case (flow_kind)
      FLOW_BREQ,
      FLOW_BRNE:   npc_d = br_taken ? br_pc : seq_pc;
      FLOW_JMP,
      FLOW_CALL:   npc_d = jmp_pc;
      FLOW_REGJMP: npc_d = jr_val_i;
      default:     npc_d = seq_pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc_o       <= RESET_PC;
      link_we_o   <= 1'b0;
      link_data_o <= '0;
    end else begin
      npc_o       <= npc_d;
      link_we_o   <= is_call;
      link_data_o <= seq_pc;
    end
  end

  assign link_reg_o = REGIDX_W'(LINK_REG);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_i,
  input logic [31:0] instr_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] rt_val_i,
  input logic [31:0] jr_val_i,
  input logic [31:0] npc_o,
  input logic        link_we_o,
  input logic [4:0]  link_reg_o,
  input logic [31:0] link_data_o
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic [5:0]  op_now;
  logic [5:0]  fn_now;
  logic [31:0] nxt_now;
  logic [31:0] bofs_now;
  assign op_now   = instr_i[31:26];
  assign fn_now   = instr_i[5:0];
  assign nxt_now  = pc_i + 32'd4;
  assign bofs_now = 32'($signed(instr_i[15:0])) <<< 2;

  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> (npc_o == RESET_PC) && !link_we_o);

  assert_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(op_now) > 6'd5 || $past(op_now) == 6'd1 ||
     ($past(op_now) == 6'd0 && $past(fn_now) != 6'b001000))
    |-> npc_o == $past(nxt_now));

  assert_beq_taken_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(op_now) == 6'd4 && $past(rs_val_i == rt_val_i))
    |-> npc_o == $past(nxt_now) + $past(bofs_now));

  assert_bne_taken_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(op_now) == 6'd5 && $past(rs_val_i != rt_val_i))
    |-> npc_o == $past(nxt_now) + $past(bofs_now));

  assert_jump_region_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(op_now) == 6'd2 || $past(op_now) == 6'd3)
    |-> (npc_o[31:28] == $past(nxt_now[31:28])) && (npc_o[27:2] == $past(instr_i[25:0]))
        && (npc_o[1:0] == 2'b00));

  assert_regjump_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(op_now) == 6'd0 && $past(fn_now) == 6'b001000)
    |-> npc_o == $past(jr_val_i));

  assert_link_only_call_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    link_we_o |-> $past(op_now) == 6'd3);

  assert_link_payload_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    link_we_o |-> (link_data_o == $past(nxt_now)) && (link_reg_o == 5'd31));
endmodule

bind npc_unit npc_unit_chk #(.RESET_PC(RESET_PC)) u_npc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pc_i        (pc_i),
  .instr_i     (instr_i),
  .rs_val_i    (rs_val_i),
  .rt_val_i    (rt_val_i),
  .jr_val_i    (jr_val_i),
  .npc_o       (npc_o),
  .link_we_o   (link_we_o),
  .link_reg_o  (link_reg_o),
  .link_data_o (link_data_o)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0, instr_i = '0, rs_val_i = '0, rt_val_i = '0, jr_val_i = '0;
  logic [31:0] npc_o;
  logic        link_we_o;
  logic [4:0]  link_reg_o;
  logic [31:0] link_data_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  npc_unit #(.RESET_PC(RST_PC), .LINK_REG(31)) i_npc_unit (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .instr_i(instr_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .jr_val_i(jr_val_i),
    .npc_o(npc_o), .link_we_o(link_we_o), .link_reg_o(link_reg_o),
    .link_data_o(link_data_o)
  );

  typedef struct {
    logic [31:0] npc;
    logic        we;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // reference model written from the requirements
  function automatic exp_t model(input logic [31:0] pc, input logic [31:0] ins,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [31:0] r, input string tag);
    exp_t e;
    int   op;
    int   off;
    logic [31:0] after;
    op    = int'(ins >> 26);
    after = pc + 4;
    off   = int'($signed(ins[15:0])) * 4;
    e.tag  = tag;
    e.we   = 1'b0;
    e.data = after;
    e.npc  = after;
    if ((op == 4 && a == b) || (op == 5 && a != b))
      e.npc = after + 32'(off);
    else if (op == 2 || op == 3)
      e.npc = (after & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) * 4);
    else if (op == 0 && (ins & 32'h3F) == 32'h8)
      e.npc = r;
    if (op == 3) e.we = 1'b1;
    return e;
  endfunction

  task automatic drive(input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] r, input string tag);
    @(negedge clk);
    pc_i = pc; instr_i = ins; rs_val_i = a; rt_val_i = b; jr_val_i = r;
    sb.push_back(model(pc, ins, a, b, r, tag));
  endtask

  // monitor: each item is due just after the edge that follows its drive
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(npc_o == e.npc, {e.tag, " npc"}, npc_o, e.npc);
      check(link_we_o == e.we, {e.tag, " R9 link_we"}, 32'(link_we_o), 32'(e.we));
      if (e.we) begin
        check(link_data_o == e.data, {e.tag, " R7 link_data"}, link_data_o, e.data);
        check(link_reg_o == 5'd31, {e.tag, " R7 link_reg"}, 32'(link_reg_o), 32'd31);
      end
    end
  end

  function automatic logic [31:0] itype(input int op, input logic [15:0] imm);
    return {6'(op), 5'd3, 5'd4, imm};
  endfunction

  function automatic logic [31:0] jtype(input int op, input logic [25:0] tgt);
    return {6'(op), tgt};
  endfunction

  initial begin
    #(4 * 50000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(npc_o == RST_PC, "R1 reset npc", npc_o, RST_PC);
    check(link_we_o == 1'b0, "R1 reset link_we", 32'(link_we_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sb.delete();

    // R2: ordinary immediate op and opcode-0 word that is not a register jump
    drive(32'h0000_1000, itype(8, 16'h0005), 0, 0, 32'hDEAD_BEE0, "R2 addi");
    drive(32'h0000_1004, {6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20}, 0, 0, 32'hDEAD_BEE0, "R2 rtype add");
    // R3: equal branch taken / not taken
    drive(32'h0000_2000, itype(4, 16'd25), 32'h55, 32'h55, 0, "R3 beq taken");
    drive(32'h0000_2000, itype(4, 16'd25), 32'h55, 32'h56, 0, "R3 beq not taken");
    // R4: not-equal branch
    drive(32'h0000_3000, itype(5, 16'd7), 32'h1, 32'h2, 0, "R4 bne taken");
    drive(32'h0000_3000, itype(5, 16'd7), 32'h9, 32'h9, 0, "R4 bne not taken");
    // R5: backward branch
    drive(32'h0000_2000, itype(4, 16'hFFFD), 32'h0, 32'h0, 0, "R5 beq backward");
    drive(32'h0000_0010, itype(5, 16'h8000), 32'h1, 32'h0, 0, "R5 bne min offset");
    // R6: absolute jump, target 2500 gives 10000
    drive(32'h0000_0000, jtype(2, 26'd2500), 0, 0, 0, "R6 jump");
    // R7: call
    drive(32'h0000_0400, jtype(3, 26'h123), 0, 0, 0, "R7 call");
    // R10: jump from last word of a region
    drive(32'h0FFF_FFFC, jtype(2, 26'h10), 0, 0, 0, "R10 region cross");
    drive(32'h5FFF_FFFC, jtype(3, 26'h3FF_FFFF), 0, 0, 0, "R10 call region cross");
    // R8: register jump
    drive(32'h0000_0800, {6'd0, 5'd31, 15'd0, 6'b001000}, 0, 0, 32'h8000_1234, "R8 regjump");
    // R11: dense alternating stream, each result one cycle later
    for (int k = 0; k < 8; k++) begin
      drive(32'h0004_0000 + 32'(k * 4), (k % 2) ? jtype(3, 26'(k * 16)) : itype(4, 16'(k)),
            32'(k), 32'(k & 2), 32'h0, "R11 stream");
    end
    drive(32'h0000_9000, itype(9, 16'h0), 0, 0, 0, "R9 non-call clears link");
    @(negedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R11 scoreboard drained", 32'(sb.size()), 32'd0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule